// File: doc/BRIEF.md
# Five-Phase Multi-Cycle Load/Store Core

A compact 32-bit load/store processor. Each instruction runs through five strictly sequential phases, and no two instructions overlap. In the first phase the word addressed by the program counter is latched into the instruction register, and the PC is advanced by 4. The second phase decodes the opcode and latches two register-file operands. In the third phase the ALU computes a sum, a difference or a pass-through. For memory instructions that result is captured in a memory address register, and a taken branch reloads the PC. The fourth phase accesses data memory, with load data captured in a memory data register. The fifth phase writes the result back to the destination register.

Code and data memory are small word arrays inside the block. A test port fills both memories while reset is held, and after the program halts it reads data memory back. Programs report their register results by storing them to data memory. A halt opcode freezes the sequencer and raises a halted flag. Any opcode that is not recognised behaves the same way.

Top module: `phase5_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, `phase_o` is 0 and `halted` is 0. Every general register reads as 0 after reset.
- R2: Opcode 001010 (bits 31:26) is add: rd (25:21) takes rs (20:16) plus rt (15:11). Bits 10:0 have no effect.
- R3: Opcode 000101 is sub: rd takes rs minus rt, computed modulo 2^32.
- R4: Opcode 000001 (addi) writes rs plus the sign-extended constant in bits 15:0 to rd. Opcode 000110 (ldi) writes the sign-extended constant itself to rd.
- R5: Opcode 000011 (ldr) loads rd from data word rs plus the sign-extended constant. Opcode 000010 (ld) loads from data word rs and ignores the constant. Data memory is word indexed by the low address bits.
- R6: Opcode 000100 (str) writes the value of the register named in the rd field to data word rs plus the sign-extended constant. No register changes.
- R7: Opcode 000111 (bne) compares the registers named in rd and rs. When they differ, the PC is loaded with the sign-extended bits 15:0 as a byte address. When they are equal, execution continues at the next word.
- R8: Phases follow the order fetch(0), decode(1), ALU(2), memory(3), write-back(4), then fetch again. The PC rises by exactly 4 on leaving fetch. A program of N instructions followed by a halt raises `halted` 5N+2 clock edges after reset is released.
- R9: Opcode 111111, and every opcode not listed here, moves the core from decode into the halt phase (5). The core then asserts `halted` and holds the PC at the halting word's address plus 4. No later instruction executes.
- R10: Register r0 is an ordinary register: it can be written and then read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of PC, phase, datapath registers and register file |
| tst_imem_we | input | 1 | Test write strobe for code memory |
| tst_imem_addr | input | IA_W | Code memory word index for test write |
| tst_imem_wdata | input | 32 | Instruction word for test write |
| tst_dmem_we | input | 1 | Test write strobe for data memory (priority over the core) |
| tst_dmem_addr | input | DA_W | Data memory word index for test write |
| tst_dmem_wdata | input | 32 | Data word for test write |
| tst_dmem_raddr | input | DA_W | Data memory word index for test read |
| tst_dmem_rdata | output | 32 | Combinational data memory read-back |
| pc_o | output | 32 | Program counter (byte address) |
| phase_o | output | 3 | Current phase code |
| halted | output | 1 | High once the core has stopped |

## Verification
The bound checker checks the phase ordering on every cycle, including the two legal exits from decode. It also checks the +4 PC step on leaving fetch, that the PC stays unchanged in decode, memory and write-back, and that the halt state is sticky with a frozen PC. Instruction semantics cannot be seen from these ports in any single cycle, so only the bench's programs can show them. Those programs cover sign-extended constants, both load addressing forms, stores that take their data from the rd field, taken and untaken branches, unknown opcodes, and the 5N+2 cycle count. Each program result is compared with an instruction-level model in the bench.

// File: rtl/p5_pkg.sv
package p5_pkg;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_MEM    = 3'd3,
        PH_WB     = 3'd4,
        PH_HALT   = 3'd5
    } phase_e;

    localparam logic [5:0] OP_ADD  = 6'b001010;
    localparam logic [5:0] OP_SUB  = 6'b000101;
    localparam logic [5:0] OP_ADDI = 6'b000001;
    localparam logic [5:0] OP_LD   = 6'b000010;
    localparam logic [5:0] OP_LDR  = 6'b000011;
    localparam logic [5:0] OP_STR  = 6'b000100;
    localparam logic [5:0] OP_LDI  = 6'b000110;
    localparam logic [5:0] OP_BNE  = 6'b000111;
    localparam logic [5:0] OP_HALT = 6'b111111;

    typedef struct packed {
        logic do_add;
        logic do_sub;
        logic use_imm;
        logic imm_zero;
        logic y_from_rd;
        logic mem_rd;
        logic mem_wr;
        logic reg_wr;
        logic wb_from_mdr;
        logic is_branch;
        logic is_halt;
    } ctrl_t;

endpackage

// File: rtl/p5_decode.sv
module p5_decode
    import p5_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctl
);

    always_comb begin
        ctl = '0;
        unique case (opcode)
            OP_ADD: begin
                ctl.do_add = 1'b1;
                ctl.reg_wr = 1'b1;
            end
            OP_SUB: begin
                ctl.do_sub = 1'b1;
                ctl.reg_wr = 1'b1;
            end
            OP_ADDI: begin
                ctl.do_add  = 1'b1;
                ctl.use_imm = 1'b1;
                ctl.reg_wr  = 1'b1;
            end
            OP_LD: begin
                ctl.do_add      = 1'b1;
                ctl.use_imm     = 1'b1;
                ctl.imm_zero    = 1'b1;
                ctl.mem_rd      = 1'b1;
                ctl.reg_wr      = 1'b1;
                ctl.wb_from_mdr = 1'b1;
            end
            OP_LDR: begin
                ctl.do_add      = 1'b1;
                ctl.use_imm     = 1'b1;
                ctl.mem_rd      = 1'b1;
                ctl.reg_wr      = 1'b1;
                ctl.wb_from_mdr = 1'b1;
            end
            OP_STR: begin
                ctl.do_add    = 1'b1;
                ctl.use_imm   = 1'b1;
                ctl.mem_wr    = 1'b1;
                ctl.y_from_rd = 1'b1;
            end
            OP_LDI: begin
                ctl.use_imm = 1'b1;
                ctl.reg_wr  = 1'b1;
            end
            OP_BNE: begin
                ctl.is_branch = 1'b1;
                ctl.y_from_rd = 1'b1;
            end
            OP_HALT: begin
                ctl.is_halt = 1'b1;
            end
            default: begin
                ctl.is_halt = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/p5_alu.sv
module p5_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_add,
    input  logic         do_sub,
    output logic [W-1:0] y
);

    always_comb begin
        if (do_add)      y = a + b;
        else if (do_sub) y = a - b;
        else             y = b;
    end

endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_x,
    input  logic [AW-1:0] ra_y,
    output logic [W-1:0]  rd_x,
    output logic [W-1:0]  rd_y,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd_x = regs[ra_x];
    assign rd_y = regs[ra_y];

endmodule

// File: rtl/phase5_core.sv
module phase5_core
    import p5_pkg::*;
#(
    parameter int  IMEM_WORDS = 64,
    parameter int  DMEM_WORDS = 64,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tst_imem_we,
    input  logic [IA_W-1:0] tst_imem_addr,
    input  logic [31:0]     tst_imem_wdata,
    input  logic            tst_dmem_we,
    input  logic [DA_W-1:0] tst_dmem_addr,
    input  logic [31:0]     tst_dmem_wdata,
    input  logic [DA_W-1:0] tst_dmem_raddr,
    output logic [31:0]     tst_dmem_rdata,
    output logic [31:0]     pc_o,
    output logic [2:0]      phase_o,
    output logic            halted
);

    localparam int NREGS = 32;
    localparam int RA_W  = $clog2(NREGS);

    phase_e ph_q, ph_d;

    logic [31:0]     pc_q, ir_q, x_q, y_q, alu_q, mdr_q;
    logic [DA_W-1:0] mar_q;

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    // instruction fields
    logic [5:0]      f_op;
    logic [RA_W-1:0] f_rd, f_rs, f_rt;
    logic [31:0]     imm_sx;

    assign f_op   = ir_q[31:26];
    assign f_rd   = ir_q[25:21];
    assign f_rs   = ir_q[20:16];
    assign f_rt   = ir_q[15:11];
    assign imm_sx = {{16{ir_q[15]}}, ir_q[15:0]};

    ctrl_t ctl;

    p5_decode dec_i (
        .opcode (f_op),
        .ctl    (ctl)
    );

    // register file
    logic [RA_W-1:0] ra_y;
    logic [31:0]     rf_x, rf_y, wb_data;
    logic            wb_en;

    assign ra_y    = ctl.y_from_rd ? f_rd : f_rt;
    assign wb_en   = (ph_q == PH_WB) && ctl.reg_wr;
    assign wb_data = ctl.wb_from_mdr ? mdr_q : alu_q;

    p5_regfile #(.W(32), .NREGS(NREGS)) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_x  (f_rs),
        .ra_y  (ra_y),
        .rd_x  (rf_x),
        .rd_y  (rf_y),
        .we    (wb_en),
        .wa    (f_rd),
        .wd    (wb_data)
    );

    // operand mux and ALU
    logic [31:0] alu_b, alu_y;

    assign alu_b = ctl.use_imm ? (ctl.imm_zero ? 32'd0 : imm_sx) : y_q;

    p5_alu #(.W(32)) alu_i (
        .a      (x_q),
        .b      (alu_b),
        .do_add (ctl.do_add),
        .do_sub (ctl.do_sub),
        .y      (alu_y)
    );

    // phase sequencer: next state
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_FETCH:  ph_d = PH_DECODE;
            PH_DECODE: ph_d = ctl.is_halt ? PH_HALT : PH_EXEC;
            PH_EXEC:   ph_d = PH_MEM;
            PH_MEM:    ph_d = PH_WB;
            PH_WB:     ph_d = PH_FETCH;
            PH_HALT:   ph_d = PH_HALT;
            default:   ph_d = PH_HALT;
        endcase
    end

    // phase sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_FETCH;
        else        ph_q <= ph_d;
    end

    // datapath registers, driven per phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            x_q   <= '0;
            y_q   <= '0;
            alu_q <= '0;
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            unique case (ph_q)
                PH_FETCH: begin
                    ir_q <= imem[pc_q[IA_W+1:2]];
                    pc_q <= pc_q + 32'd4;
                end
                PH_DECODE: begin
                    x_q <= rf_x;
                    y_q <= rf_y;
                end
                PH_EXEC: begin
                    alu_q <= alu_y;
                    if (ctl.mem_rd || ctl.mem_wr) mar_q <= alu_y[DA_W-1:0];
                    if (ctl.is_branch && (x_q != y_q)) pc_q <= imm_sx;
                end
                PH_MEM: begin
                    if (ctl.mem_rd) mdr_q <= dmem[mar_q];
                end
                PH_WB:   ;
                PH_HALT: ;
                default: ;
            endcase
        end
    end

    // memories
    always_ff @(posedge clk) begin
        if (tst_imem_we) imem[tst_imem_addr] <= tst_imem_wdata;
    end

    always_ff @(posedge clk) begin
        if (tst_dmem_we)
            dmem[tst_dmem_addr] <= tst_dmem_wdata;
        else if ((ph_q == PH_MEM) && ctl.mem_wr)
            dmem[mar_q] <= y_q;
    end

    assign tst_dmem_rdata = dmem[tst_dmem_raddr];
    assign pc_o           = pc_q;
    assign phase_o        = ph_q;
    assign halted         = (ph_q == PH_HALT);

endmodule

// File: rtl/phase5_core_chk.sv
module phase5_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  phase_o,
    input logic [31:0] pc_o,
    input logic        halted
);

    assert_fetch_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd0) |=> (phase_o == 3'd1));

    assert_decode_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd1) |=> (phase_o == 3'd2 || phase_o == 3'd5));

    assert_exec_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd2) |=> (phase_o == 3'd3));

    assert_mem_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd3) |=> (phase_o == 3'd4));

    assert_wb_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd4) |=> (phase_o == 3'd0));

    assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd0) |=> (pc_o == $past(pc_o) + 32'd4));

    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd1 || phase_o == 3'd3 || phase_o == 3'd4) |=> $stable(pc_o));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_o)));

endmodule

bind phase5_core phase5_core_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase_o),
    .pc_o    (pc_o),
    .halted  (halted)
);

// File: tb/phase5_core_tb_top.sv
module phase5_core_tb_top;

    localparam int WORDS = 64;
    localparam int AW    = 6;

    localparam logic [5:0] K_ADD = 6'b001010, K_SUB = 6'b000101, K_ADDI = 6'b000001,
                           K_LD  = 6'b000010, K_LDR = 6'b000011, K_STR  = 6'b000100,
                           K_LDI = 6'b000110, K_BNE = 6'b000111, K_HALT = 6'b111111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tst_imem_we = 1'b0;
    logic [AW-1:0] tst_imem_addr = '0;
    logic [31:0]   tst_imem_wdata = '0;
    logic          tst_dmem_we = 1'b0;
    logic [AW-1:0] tst_dmem_addr = '0;
    logic [31:0]   tst_dmem_wdata = '0;
    logic [AW-1:0] tst_dmem_raddr = '0;
    logic [31:0]   tst_dmem_rdata;
    logic [31:0]   pc_o;
    logic [2:0]    phase_o;
    logic          halted;

    always #2 clk = ~clk;

    phase5_core #(.IMEM_WORDS(WORDS), .DMEM_WORDS(WORDS)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tst_imem_we    (tst_imem_we),
        .tst_imem_addr  (tst_imem_addr),
        .tst_imem_wdata (tst_imem_wdata),
        .tst_dmem_we    (tst_dmem_we),
        .tst_dmem_addr  (tst_dmem_addr),
        .tst_dmem_wdata (tst_dmem_wdata),
        .tst_dmem_raddr (tst_dmem_raddr),
        .tst_dmem_rdata (tst_dmem_rdata),
        .pc_o           (pc_o),
        .phase_o        (phase_o),
        .halted         (halted)
    );

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] p_mem   [WORDS];
    logic [31:0] dm_init [WORDS];
    logic [31:0] m_rf    [32];
    logic [31:0] m_dm    [WORDS];
    int          pn;

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] op, input int rd, input int rs, input int rt);
        return {op, rd[4:0], rs[4:0], rt[4:0], 11'h5a5};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rd, input int rs, input int c);
        return {op, rd[4:0], rs[4:0], c[15:0]};
    endfunction

    function automatic logic [31:0] sx(input logic [31:0] w);
        return {{16{w[15]}}, w[15:0]};
    endfunction

    task automatic prog_clear();
        for (int i = 0; i < WORDS; i++) begin
            p_mem[i]   = {K_HALT, 26'd0};
            dm_init[i] = '0;
        end
        pn = 0;
    endtask

    task automatic emit(input logic [31:0] w);
        p_mem[pn] = w;
        pn++;
    endtask

    // instruction-level model; returns executed count (halt excluded)
    function automatic int iss_run();
        logic [31:0] pc, w, a;
        int          n;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < WORDS; i++) m_dm[i] = dm_init[i];
        pc = 0;
        n  = 0;
        while (n < 1000) begin
            w  = p_mem[pc[AW+1:2]];
            pc = pc + 4;
            a  = m_rf[w[20:16]] + sx(w);
            case (w[31:26])
                K_ADD:  m_rf[w[25:21]] = m_rf[w[20:16]] + m_rf[w[15:11]];
                K_SUB:  m_rf[w[25:21]] = m_rf[w[20:16]] - m_rf[w[15:11]];
                K_ADDI: m_rf[w[25:21]] = a;
                K_LDI:  m_rf[w[25:21]] = sx(w);
                K_LD:   m_rf[w[25:21]] = m_dm[m_rf[w[20:16]][AW-1:0]];
                K_LDR:  m_rf[w[25:21]] = m_dm[a[AW-1:0]];
                K_STR:  m_dm[a[AW-1:0]] = m_rf[w[25:21]];
                K_BNE:  if (m_rf[w[25:21]] != m_rf[w[20:16]]) pc = sx(w);
                default: return n;
            endcase
            n++;
        end
        return n;
    endfunction

    task automatic run_prog(input bit chk_reset, output int cycles);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < WORDS; i++) begin
            tst_imem_we = 1'b1; tst_imem_addr = AW'(i); tst_imem_wdata = p_mem[i];
            tst_dmem_we = 1'b1; tst_dmem_addr = AW'(i); tst_dmem_wdata = dm_init[i];
            @(negedge clk);
        end
        tst_imem_we = 1'b0;
        tst_dmem_we = 1'b0;
        if (chk_reset) begin
            check32("R1 pc in reset", pc_o, 32'd0);
            check32("R1 phase in reset", {29'd0, phase_o}, 32'd0);
            check32("R1 halted in reset", {31'd0, halted}, 32'd0);
        end
        rst_n  = 1'b1;
        cycles = 0;
        while (!halted && cycles < 3000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
        if (!halted) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 run watchdog: actual running expected halted");
        end
    endtask

    function automatic logic [31:0] peek(input int a);
        return 32'd0;
    endfunction

    task automatic dm_read(input int a, output logic [31:0] v);
        tst_dmem_raddr = AW'(a);
        #1;
        v = tst_dmem_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL global watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        int          cyc, n;
        logic [31:0] v;
        void'($urandom(32'h0005eed5));

        // Program A: arithmetic, constants, stores, r0 writable, cleared registers
        prog_clear();
        emit(enc_i(K_LDI, 0, 0, 7));
        emit(enc_i(K_LDI, 1, 0, -3));
        emit(enc_r(K_ADD, 2, 0, 1));
        emit(enc_r(K_SUB, 3, 0, 1));
        emit(enc_i(K_ADDI, 4, 1, -5));
        emit(enc_i(K_STR, 2, 0, 1));
        emit(enc_i(K_STR, 3, 0, 2));
        emit(enc_i(K_STR, 4, 0, 3));
        emit(enc_i(K_STR, 0, 0, 4));
        emit(enc_i(K_STR, 5, 0, 5));
        run_prog(1'b1, cyc);
        dm_read(8, v);  check32("R2 add with junk low bits", v, 32'd4);
        dm_read(9, v);  check32("R3 sub", v, 32'd10);
        dm_read(10, v); check32("R4 addi negative constant", v, 32'hffff_fff8);
        dm_read(11, v); check32("R10 r0 written", v, 32'd7);
        dm_read(12, v); check32("R1 register cleared by reset", v, 32'd0);
        check32("R8 cycles to halt", cyc, 32'd52);
        check32("R9 pc after halt", pc_o, 32'd44);

        // Program B: both load forms
        prog_clear();
        dm_init[3] = 32'd145;
        dm_init[5] = 32'd231;
        emit(enc_i(K_LDI, 1, 0, 3));
        emit(enc_i(K_LD, 9, 1, 2));
        emit(enc_i(K_LDR, 8, 1, 2));
        emit(enc_i(K_LDI, 2, 0, 6));
        emit(enc_i(K_LDR, 7, 2, -1));
        emit(enc_i(K_STR, 9, 0, 20));
        emit(enc_i(K_STR, 8, 0, 21));
        emit(enc_i(K_STR, 7, 0, 22));
        run_prog(1'b0, cyc);
        dm_read(20, v); check32("R5 ld ignores constant", v, 32'd145);
        dm_read(21, v); check32("R5 ldr rs+c", v, 32'd231);
        dm_read(22, v); check32("R5 ldr negative offset", v, 32'd231);
        dm_read(3, v);  check32("R6 str leaves source word", v, 32'd145);

        // Program C: counted loop with taken bne, then untaken bne
        prog_clear();
        emit(enc_i(K_LDI, 0, 0, 0));
        emit(enc_i(K_LDI, 1, 0, 4));
        emit(enc_i(K_LDI, 2, 0, 0));
        emit(enc_i(K_ADDI, 0, 0, 1));
        emit(enc_i(K_ADDI, 2, 2, 3));
        emit(enc_i(K_BNE, 0, 1, 12));
        emit(enc_i(K_STR, 2, 1, 26));
        emit(enc_i(K_BNE, 0, 0, 0));
        emit(enc_i(K_STR, 0, 1, 27));
        run_prog(1'b0, cyc);
        dm_read(30, v); check32("R7 taken loop result", v, 32'd12);
        dm_read(31, v); check32("R7 untaken falls through", v, 32'd4);
        check32("R8 loop cycle count", cyc, 32'd92);

        // Program D: unknown opcode stops the core
        prog_clear();
        dm_init[40] = 32'h0000_dead;
        emit(enc_i(K_LDI, 3, 0, 9));
        emit({6'b110011, 26'h0});
        emit(enc_i(K_STR, 3, 0, 40));
        run_prog(1'b0, cyc);
        check32("R9 unknown opcode cycles", cyc, 32'd7);
        repeat (20) @(negedge clk);
        check32("R9 stays halted", {31'd0, halted}, 32'd1);
        check32("R9 pc frozen", pc_o, 32'd8);
        check32("R9 phase code", {29'd0, phase_o}, 32'd5);
        dm_read(40, v); check32("R9 later store not run", v, 32'h0000_dead);

        // Random straight-line programs checked against the model
        for (int t = 0; t < 8; t++) begin
            prog_clear();
            emit(enc_i(K_LDI, 31, 0, 48));
            for (int k = 0; k < 14; k++) begin
                int kind, rd, rs, rt, c;
                kind = int'($urandom % 4);
                rd   = int'($urandom % 8);
                rs   = int'($urandom % 8);
                rt   = int'($urandom % 8);
                c    = int'($urandom % 65536) - 32768;
                case (kind)
                    0: emit(enc_i(K_LDI, rd, 0, c));
                    1: emit(enc_i(K_ADDI, rd, rs, c));
                    2: emit(enc_r(K_ADD, rd, rs, rt));
                    default: emit(enc_r(K_SUB, rd, rs, rt));
                endcase
            end
            for (int r = 0; r < 8; r++) emit(enc_i(K_STR, r, 31, r));
            n = iss_run();
            run_prog(1'b0, cyc);
            for (int r = 0; r < 8; r++) begin
                dm_read(48 + r, v);
                check32("R2 R3 R4 random arithmetic", v, m_dm[48 + r]);
            end
            check32("R8 random cycle count", cyc, 32'(5 * n + 2));
        end

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule